// File: doc/BRIEF.md
# Shared Capture/Compare Timer Channel

This block is a single timer channel. A mode bit decides its role: it either captures the value of a free-running counter when a chosen edge arrives on its pin, or it compares the counter against a stored value and changes its pin's output latch on a match. One W-bit register serves both roles. In capture mode it holds the last captured count. In compare mode it holds the match value. The pin can also serve as general-purpose I/O, because a direction bit alone decides whether the pin is driven.

Software reaches the channel through a plain register port. A write is one cycle with `wr_en` high. A read is combinational from `addr`. There is no streaming data path, so no valid/ready handshake and no back-pressure apply; every write is accepted in the cycle it is presented. A single event flag reports captures and matches. The counter and any interrupt logic sit outside the block.

Register map: address 0 is the shared value. Address 1 is control:
- bit 0: mode, 0 = compare, 1 = capture
- bit 1: direction, 1 = drive
- bits 3:2: edge select
- bits 5:4: match action

Address 2 is the flag at bit 0. Address 3 is the pin: a write of bit 0 loads the output latch, and a read of bit 0 returns the synchronized pin level.

Top module: `cc_chan`

## Requirements
- R1: After reset, every field is zero: mode, direction, edge select, action, value, flag and output latch. So `pin_oe` = 0, `pin_out` = 0, and compare mode is selected.
- R2: `pin_oe` equals the direction bit (control bit 1) in both modes, one cycle after the control write.
- R3: In capture mode a qualifying edge copies `cnt` into the value register and sets the flag. The edge passes a 2-stage synchronizer. If `pin_in` changes before clock edge k, the count captured is the `cnt` present at edge k+2, and nothing changes at edge k+1.
- R4: Edge select (control bits 3:2) works as follows: 00 captures on no edge, 01 on rising edges only, 10 on falling edges only, 11 on both.
- R5: In capture mode, bus writes to address 0 leave the value unchanged while `test_frz` = 0. While `test_frz` = 1, such writes load the value.
- R6: In compare mode, address 0 is an ordinary read/write register.
- R7: In compare mode, `cnt` equal to the value at a clock edge sets the flag at that edge and applies the action (control bits 5:4) to the output latch. The actions are: 00 keep, 01 toggle, 10 clear, 11 set.
- R8: Capture mode makes no match and never alters the latch. Compare mode never captures.
- R9: Writing 1 to address 2 bit 0 clears the flag, and writing 0 has no effect. A capture or match in the same cycle wins over the clear.
- R10: Address 3 behaves as follows. A write of bit 0 loads the output latch. A read returns the synchronized pin level in bit 0. A match action in the same cycle wins over the write.
- R11: In capture mode with `test_frz` = 1, a capture in the same cycle as a value write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt | input | W | Free-running counter value |
| pin_in | input | 1 | Pin level (asynchronous) |
| pin_out | output | 1 | Output latch driven to the pin |
| pin_oe | output | 1 | Pin output enable |
| test_frz | input | 1 | Test/freeze mode, unlocks capture-mode writes |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | W | Write data |
| rdata | output | W | Read data (combinational) |
| flag | output | 1 | Event flag |

## Verification
Several pairs of functions can land on the same clock edge:
- an event setting the flag while software clears it;
- a match action while software writes the pin latch;
- a capture while a freeze-mode write targets the shared value.

The bench steers the counter and the pin so that each event lands exactly on the edge that consumes a write. It then judges the winner from the register contents one cycle later. Capture timing is checked at the exact edge, with the expected count worked out from the bench's own counter.

// File: rtl/cc_pkg.sv
package cc_pkg;
  typedef enum logic [1:0] {EDGE_OFF, EDGE_RISE, EDGE_FALL, EDGE_ANY} edge_e;
  typedef enum logic [1:0] {ACT_KEEP, ACT_TOGGLE, ACT_CLEAR, ACT_SET} act_e;

  typedef struct packed {
    act_e  act;
    edge_e edg;
    logic  dir;
    logic  fsel;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam logic [1:0] A_VAL  = 2'd0;
  localparam logic [1:0] A_CTRL = 2'd1;
  localparam logic [1:0] A_FLAG = 2'd2;
  localparam logic [1:0] A_PIN  = 2'd3;
endpackage

// File: rtl/cc_pin_sync.sv
module cc_pin_sync
  import cc_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pin_in,
  input  edge_e edge_sel,
  output logic  pin_s,
  output logic  edge_hit
);
  logic [STAGES-1:0] sr;
  logic prev;
  logic rise, fall;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) sr[0] <= 1'b0;
        else        sr[0] <= pin_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) sr[i] <= 1'b0;
        else        sr[i] <= sr[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= sr[STAGES-1];
  end

  assign pin_s = sr[STAGES-1];
  assign rise  = pin_s & ~prev;
  assign fall  = ~pin_s & prev;

  always_comb begin
    unique case (edge_sel)
      EDGE_RISE: edge_hit = rise;
      EDGE_FALL: edge_hit = fall;
      EDGE_ANY:  edge_hit = rise | fall;
      default:   edge_hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/cc_cmp_act.sv
module cc_cmp_act
  import cc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] value,
  input  logic         armed,
  input  act_e         act,
  input  logic         cur,
  output logic         hit,
  output logic         nxt
);
  assign hit = armed && (cnt == value);

  always_comb begin
    unique case (act)
      ACT_TOGGLE: nxt = ~cur;
      ACT_CLEAR:  nxt = 1'b0;
      ACT_SET:    nxt = 1'b1;
      default:    nxt = cur;
    endcase
  end
endmodule

// File: rtl/cc_regs.sv
module cc_regs
  import cc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  input  logic         test_frz,
  input  logic [W-1:0] cnt,
  input  logic         edge_hit,
  input  logic         pin_s,
  input  logic         match_hit,
  input  logic         match_nxt,
  output ctrl_t        ctrl,
  output logic [W-1:0] value,
  output logic         flag,
  output logic         latch,
  output logic [W-1:0] rdata
);
  localparam int PAD = W - CTRL_W;

  logic wr_val, wr_ctrl, wr_flag, wr_pin;
  logic cap_hit;

  assign wr_val  = wr_en && (addr == A_VAL);
  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign wr_flag = wr_en && (addr == A_FLAG);
  assign wr_pin  = wr_en && (addr == A_PIN);
  assign cap_hit = ctrl.fsel && edge_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl  <= '{act: ACT_KEEP, edg: EDGE_OFF, dir: 1'b0, fsel: 1'b0};
      value <= '0;
      flag  <= 1'b0;
      latch <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);

      if (cap_hit)                                value <= cnt;
      else if (wr_val && (!ctrl.fsel || test_frz)) value <= wdata;

      if (cap_hit || match_hit)     flag <= 1'b1;
      else if (wr_flag && wdata[0]) flag <= 1'b0;

      if (match_hit)   latch <= match_nxt;
      else if (wr_pin) latch <= wdata[0];
    end
  end

  always_comb begin
    unique case (addr)
      A_VAL:   rdata = value;
      A_CTRL:  rdata = {{PAD{1'b0}}, ctrl};
      A_FLAG:  rdata = {{(W-1){1'b0}}, flag};
      default: rdata = {{(W-1){1'b0}}, pin_s};
    endcase
  end
endmodule

// File: rtl/cc_chan.sv
module cc_chan
  import cc_pkg::*;
#(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt,
  input  logic         pin_in,
  output logic         pin_out,
  output logic         pin_oe,
  input  logic         test_frz,
  input  logic         wr_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         flag
);
  ctrl_t        ctrl_q;
  logic [W-1:0] value_q;
  logic         latch_q;
  logic         pin_s, edge_hit;
  logic         match_hit, match_nxt;

  cc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .edge_sel(ctrl_q.edg),
    .pin_s(pin_s), .edge_hit(edge_hit)
  );

  cc_cmp_act #(.W(W)) u_cmp (
    .cnt(cnt), .value(value_q), .armed(!ctrl_q.fsel), .act(ctrl_q.act),
    .cur(latch_q), .hit(match_hit), .nxt(match_nxt)
  );

  cc_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .test_frz(test_frz), .cnt(cnt), .edge_hit(edge_hit), .pin_s(pin_s),
    .match_hit(match_hit), .match_nxt(match_nxt),
    .ctrl(ctrl_q), .value(value_q), .flag(flag), .latch(latch_q), .rdata(rdata)
  );

  assign pin_out = latch_q;
  assign pin_oe  = ctrl_q.dir;
endmodule

// File: rtl/cc_chan_chk.sv
module cc_chan_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] cnt,
  input logic         wr_en,
  input logic [1:0]   addr,
  input logic [W-1:0] wdata,
  input logic         test_frz,
  input logic         fsel,
  input logic [1:0]   edge_sel,
  input logic [W-1:0] value,
  input logic         flag,
  input logic         pin_out,
  input logic         edge_hit
);
  // R3
  cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fsel && edge_hit |=> (value == $past(cnt)) && flag);

  // R5
  cap_wr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fsel && !edge_hit && !test_frz |=> $stable(value));

  // R4
  edge_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fsel && (edge_sel == 2'b00) && !test_frz |=> $stable(value));

  // R7
  match_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fsel && (cnt == value) |=> flag);

  // R9
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (addr == 2'd2) && wdata[0] && !(fsel ? edge_hit : (cnt == value)) |=> !flag);

  // R8
  cap_pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fsel && !(wr_en && (addr == 2'd3)) |=> $stable(pin_out));
endmodule

bind cc_chan cc_chan_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .test_frz(test_frz), .fsel(ctrl_q.fsel), .edge_sel(ctrl_q.edg),
  .value(value_q), .flag(flag), .pin_out(pin_out), .edge_hit(edge_hit)
);

// File: tb/sim_cc_chan.sv
module sim_cc_chan;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cnt;
  logic        pin_in, pin_out, pin_oe, test_frz, wr_en, flag;
  logic [1:0]  addr;
  logic [15:0] wdata, rdata;
  bit          run;
  int          n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  cc_chan u0 (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .test_frz(test_frz), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .flag(flag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    if (run) cnt = cnt + 16'd1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    addr = a; #1; d = rdata;
  endtask

  function automatic logic [15:0] cw(input logic fs, input logic dr,
                                     input logic [1:0] es, input logic [1:0] ac);
    return {10'b0, ac, es, dr, fs};
  endfunction

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] d, v0, x;
    logic        exp_l;
    rst_n = 1'b0; cnt = 16'hFFFF; pin_in = 1'b0; test_frz = 1'b0;
    wr_en = 1'b0; addr = 2'd0; wdata = '0; run = 1'b0;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();

    // R1 reset state
    check("R1 pin_oe", pin_oe, 0);
    check("R1 pin_out", pin_out, 0);
    check("R1 flag", flag, 0);
    rd(2'd0, d); check("R1 value", d, 0);
    rd(2'd1, d); check("R1 ctrl", d, 0);

    // R2 direction drives pin_oe in both modes
    for (int fs = 0; fs < 2; fs++)
      for (int dr = 0; dr < 2; dr++) begin
        wr(2'd1, cw(fs[0], dr[0], 2'b00, 2'b00));
        check($sformatf("R2 oe fs=%0d", fs), pin_oe, dr);
      end

    // R6 compare-mode value read/write
    wr(2'd1, cw(0, 1, 2'b00, 2'b00));
    wr(2'd0, 16'hA5C3);
    rd(2'd0, d); check("R6 value rw", d, 16'hA5C3);

    // R7 compare actions over every action and starting latch level
    for (int a = 0; a < 4; a++)
      for (int l = 0; l < 2; l++) begin
        wr(2'd1, cw(0, 1, 2'b00, a[1:0]));
        wr(2'd0, 16'h0100);
        wr(2'd3, {15'b0, l[0]});
        wr(2'd2, 16'h0001);
        check("R7 no early flag", flag, 0);
        cnt = 16'h0100;
        cyc();
        cnt = 16'hFFFF;
        case (a)
          1: exp_l = ~l[0];
          2: exp_l = 1'b0;
          3: exp_l = 1'b1;
          default: exp_l = l[0];
        endcase
        check($sformatf("R7 action=%0d latch=%0d", a, l), pin_out, exp_l);
        check("R7 flag on match", flag, 1);
      end

    // R9 flag write-1-clear, write-0 no effect, set beats clear
    wr(2'd2, 16'h0000); check("R9 write0 keeps", flag, 1);
    cnt = 16'h0100; wr(2'd2, 16'h0001); cnt = 16'hFFFF;
    check("R9 set wins", flag, 1);
    wr(2'd2, 16'h0001); check("R9 clear", flag, 0);

    // R10 pin latch write, match beats write, pin read
    wr(2'd1, cw(0, 1, 2'b00, 2'b10));
    wr(2'd3, 16'h0001); check("R10 latch write", pin_out, 1);
    cnt = 16'h0100; wr(2'd3, 16'h0001); cnt = 16'hFFFF;
    check("R10 match beats write", pin_out, 0);
    pin_in = 1'b1; repeat (3) cyc();
    rd(2'd3, d); check("R10 pin read high", d, 1);
    pin_in = 1'b0; repeat (3) cyc();
    rd(2'd3, d); check("R10 pin read low", d, 0);

    // R8 compare mode ignores pin edges
    wr(2'd1, cw(0, 1, 2'b11, 2'b01));
    wr(2'd2, 16'h0001);
    pin_in = 1'b1; repeat (4) cyc(); pin_in = 1'b0; repeat (4) cyc();
    rd(2'd0, d); check("R8 no capture in compare", d, 16'h0100);
    check("R8 no flag in compare", flag, 0);
    // R8 capture mode: no match, latch held
    wr(2'd3, 16'h0001);
    wr(2'd1, cw(1, 1, 2'b00, 2'b01));
    cnt = 16'h0100; repeat (3) cyc(); cnt = 16'hFFFF;
    check("R8 no match in capture", flag, 0);
    check("R8 latch held in capture", pin_out, 1);

    // R5 write lock in capture mode
    wr(2'd0, 16'h1234);
    rd(2'd0, d); check("R5 locked", d, 16'h0100);
    test_frz = 1'b1; wr(2'd0, 16'h1234); test_frz = 1'b0;
    rd(2'd0, d); check("R5 freeze write", d, 16'h1234);

    // R3 R4 capture sweep over edge selects and both transitions
    run = 1'b1;
    for (int es = 0; es < 4; es++)
      for (int up = 0; up < 2; up++) begin
        logic hit;
        wr(2'd1, cw(1, 0, 2'b00, 2'b00));
        pin_in = ~up[0]; repeat (4) cyc();
        wr(2'd1, cw(1, 0, es[1:0], 2'b00));
        wr(2'd2, 16'h0001);
        rd(2'd0, v0);
        pin_in = up[0]; x = cnt;
        cyc(); cyc();
        check("R3 no capture before latency", flag, 0);
        cyc();
        hit = (es == 3) || (es == 1 && up == 1) || (es == 2 && up == 0);
        rd(2'd0, d);
        check($sformatf("R4 value es=%0d up=%0d", es, up), d, hit ? x + 16'd2 : v0);
        check($sformatf("R3 flag es=%0d up=%0d", es, up), flag, hit);
      end

    // R11 capture beats simultaneous freeze write
    wr(2'd1, cw(1, 0, 2'b01, 2'b00));
    pin_in = 1'b0; repeat (4) cyc();
    pin_in = 1'b1; x = cnt;
    cyc(); cyc();
    test_frz = 1'b1; wr(2'd0, 16'hBEEF); test_frz = 1'b0;
    rd(2'd0, d); check("R11 capture wins", d, x + 16'd2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule